// File: doc/BRIEF.md
# Streaming Run-Length Encoder with Saturating Count

This block compresses a stream of bytes without loss. It accepts at most one byte per clock. It replaces each stretch of equal bytes with a pair made of the byte value and the number of times the byte repeated. The repeat count is carried in a 3-bit field, so one pair covers at most seven bytes. A longer stretch is split into several pairs for the same value.

A stream begins with a one-cycle `start` pulse, which also captures the stream length from `total_len`. Bytes then arrive on `in_data`, qualified by `in_valid`. An internal 16-bit element counter compares the number of accepted bytes with the captured length. When the last byte has been taken, the block pushes out the run still pending and raises `done`. It then stays idle until the next `start`.

Each pair appears on `out_value` and `out_count` together with a one-clock `out_valid` strobe, one clock after the edge that produced it. The reset is synchronous and active high.

Top module: `rle_sat_encoder`

## Requirements
- R1: While and right after a synchronous reset, `out_valid`, `done` and `busy` are all 0.
- R2: Consecutive equal bytes accumulate into one run. When a differing byte is accepted, the pair for the held value is emitted, and `out_count` equals the number of repetitions. The stream 35,35,35,35,40,40,72,72 yields (35,4), (40,2), (72,2).
- R3: The count saturates at 7. If a run holds 7 and the next accepted byte still matches, (value,7) is emitted and the count restarts at 1 for that same value. Nine equal bytes therefore yield (v,7) then (v,2).
- R4: Every emitted pair has `out_count` between 1 and 7, and `out_valid` is high for exactly one clock per pair.
- R5: Once `total_len` bytes have been accepted, the final pending run is emitted on the next clock. `done` rises in the same cycle that this last pair is presented, and no earlier pair of the stream is presented with `done` high.
- R6: Cycles with `in_valid` low during a stream are ignored, whatever the value on `in_data`.
- R7: `in_valid` is ignored before the first `start` and after `done`: no pair is emitted and `done` stays high.
- R8: A `start` pulse while a stream is in progress is ignored; the stream completes with its original length.
- R9: A `start` with `total_len` equal to 0 raises `done` on the next clock without emitting any pair.
- R10: A `start` after `done` clears `done` and sets `busy` on the next clock. The new stream is encoded without reference to bytes of the previous stream.
- R11: A reset during a stream abandons it: outputs return to the R1 state and the pending run is never emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a stream and captures `total_len` (used when idle or done) |
| total_len | input | 16 | Number of bytes in the stream |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | One-clock strobe for each emitted pair |
| out_value | output | 8 | Byte value of the emitted pair |
| out_count | output | 3 | Repetition count of the emitted pair (1..7) |
| done | output | 1 | High from the final pair until the next accepted `start` |
| busy | output | 1 | High while a stream is being accepted or flushed |

## Verification
The embedded properties check on every cycle that:
- an emitted count is never zero;
- a matching byte below the limit increments the run, and a saturated match restarts the run at one;
- the element counter never passes the captured length;
- `done` holds until a start arrives;
- nothing is emitted outside an active stream.

Only the bench scenarios can show that the sequence of pairs matches an independent encoding of each stream. The same holds for placing `done` on the last pair, and for the behaviour around idle gaps, ignored starts, zero length and a reset in mid-stream.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } enc_state_t;

  // Largest count a field of cnt_w bits can hold.
  function automatic int run_limit(input int cnt_w);
    return (1 << cnt_w) - 1;
  endfunction

  // A run may grow while its count is below the field limit.
  function automatic bit run_can_grow(input int cnt, input int cnt_w);
    return cnt < run_limit(cnt_w);
  endfunction

  // True when an accepted element is the final one of the stream.
  function automatic bit is_final_elem(input int taken_before, input int len);
    return (taken_before + 1) == len;
  endfunction

endpackage

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       len_zero,
  input  logic       last_take,
  output enc_state_t state,
  output logic       run_en,
  output logic       flush_now,
  output logic       restart
);

  enc_state_t state_q, state_d;

  assign restart   = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign run_en    = (state_q == ST_RUN);
  assign flush_now = (state_q == ST_FLUSH);
  assign state     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = len_zero ? ST_DONE : ST_RUN;
      ST_RUN:           if (last_take) state_d = ST_FLUSH;
      ST_FLUSH:         state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R5: done persists until a new start is seen
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && !start) |=> (state_q == ST_DONE));

  // R8: a running stream leaves RUN only through its last element
  a_r8_run_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !last_take) |=> (state_q == ST_RUN));

endmodule

// File: rtl/rle_elem_counter.sv
module rle_elem_counter
  import rle_enc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             take,
  input  logic [LEN_W-1:0] total_len,
  output logic             len_zero,
  output logic             last_take
);

  logic [LEN_W-1:0] seen_q;
  logic [LEN_W-1:0] len_q;

  assign len_zero  = (total_len == '0);
  assign last_take = take && is_final_elem(int'(seen_q), int'(len_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      len_q  <= '0;
    end else if (restart) begin
      seen_q <= '0;
      len_q  <= total_len;
    end else if (take) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R5: the element count never passes the captured length
  a_r5_count_within_len: assert property (@(posedge clk) disable iff (rst)
    seen_q <= len_q);

endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import rle_enc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              take,
  input  logic              flush,
  input  logic [DATA_W-1:0] in_data,
  output logic              emit,
  output logic [DATA_W-1:0] emit_value,
  output logic [CNT_W-1:0]  emit_count
);

  localparam logic [CNT_W-1:0] MAX_RUN = CNT_W'(run_limit(CNT_W));

  logic [DATA_W-1:0] held_q;
  logic [CNT_W-1:0]  cnt_q;      // zero means no run is pending
  logic              pending;
  logic              same_byte;
  logic              grow;

  assign pending    = (cnt_q != '0);
  assign same_byte  = (in_data == held_q);
  assign grow       = take && pending && same_byte && run_can_grow(int'(cnt_q), CNT_W);
  assign emit       = (take && pending && !grow) || (flush && pending);
  assign emit_value = held_q;
  assign emit_count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      cnt_q  <= '0;
    end else if (restart || flush) begin
      cnt_q  <= '0;
    end else if (take) begin
      if (grow) begin
        cnt_q  <= cnt_q + 1'b1;
      end else begin
        held_q <= in_data;
        cnt_q  <= CNT_W'(1);
      end
    end
  end

  // R2: a matching byte below the limit extends the run by one
  a_r2_run_grows: assert property (@(posedge clk) disable iff (rst)
    (take && pending && same_byte && cnt_q < MAX_RUN) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3: a saturated run always restarts at one
  a_r3_split_restart: assert property (@(posedge clk) disable iff (rst)
    (take && cnt_q == MAX_RUN) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/rle_pair_out.sv
module rle_pair_out #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [DATA_W-1:0] emit_value,
  input  logic [CNT_W-1:0]  emit_count,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_value,
  output logic [CNT_W-1:0]  out_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_count <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_value <= emit_value;
        out_count <= emit_count;
      end
    end
  end

  // R4: an emitted pair never carries a zero count
  a_r4_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != '0));

  // R1: the strobe is low on the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

// File: rtl/rle_sat_encoder.sv
module rle_sat_encoder
  import rle_enc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  total_len,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_value,
  output logic [CNT_W-1:0]  out_count,
  output logic              done,
  output logic              busy
);

  enc_state_t        state;
  logic              run_en;
  logic              flush_now;
  logic              restart;
  logic              take;
  logic              len_zero;
  logic              last_take;
  logic              emit;
  logic [DATA_W-1:0] emit_value;
  logic [CNT_W-1:0]  emit_count;

  assign take = run_en && in_valid;
  assign done = (state == ST_DONE);
  assign busy = run_en || flush_now;

  rle_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .len_zero  (len_zero),
    .last_take (last_take),
    .state     (state),
    .run_en    (run_en),
    .flush_now (flush_now),
    .restart   (restart)
  );

  rle_elem_counter #(.LEN_W(LEN_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .take      (take),
    .total_len (total_len),
    .len_zero  (len_zero),
    .last_take (last_take)
  );

  rle_run_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .take       (take),
    .flush      (flush_now),
    .in_data    (in_data),
    .emit       (emit),
    .emit_value (emit_value),
    .emit_count (emit_count)
  );

  rle_pair_out #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .emit       (emit),
    .emit_value (emit_value),
    .emit_count (emit_count),
    .out_valid  (out_valid),
    .out_value  (out_value),
    .out_count  (out_count)
  );

  // R7: nothing is emitted outside an active stream
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_DONE) |-> !emit);

endmodule

// File: tb/sim_rle_sat_encoder.sv
`timescale 1ns/1ps
module sim_rle_sat_encoder;

  localparam int NV = 8;
  localparam int MAXB = 12;
  localparam logic [7:0] STIM [NV][MAXB] = '{
    '{8'd35,8'd35,8'd35,8'd35,8'd40,8'd40,8'd72,8'd72,8'd0,8'd0,8'd0,8'd0},
    '{8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'h11,8'd0,8'd0,8'd0},
    '{8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA,8'hAA},
    '{8'd1,8'd2,8'd3,8'd4,8'd5,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0},
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'hFF,8'hFF,8'hFF,8'hFF},
    '{8'h5A,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0,8'd0},
    '{8'h33,8'h33,8'h33,8'h33,8'h33,8'h33,8'h33,8'h44,8'd0,8'd0,8'd0,8'd0},
    '{8'h80,8'h80,8'h81,8'h81,8'h81,8'h81,8'h81,8'h81,8'h81,8'h81,8'h80,8'h80}
  };
  localparam int STIM_LEN [NV] = '{8, 9, 12, 5, 12, 1, 8, 12};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] total_len = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid;
  logic [7:0] out_value;
  logic [2:0] out_count;
  logic done;
  logic busy;

  always #2.5 clk = ~clk;

  rle_sat_encoder u0 (
    .clk(clk), .rst(rst), .start(start), .total_len(total_len),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_value(out_value), .out_count(out_count), .done(done), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // capture of every presented pair
  int cap_n = 0;
  logic [7:0] cap_v [256];
  int cap_c [256];
  bit cap_d [256];

  always @(negedge clk) begin
    if (out_valid) begin
      cap_v[cap_n % 256] = out_value;
      cap_c[cap_n % 256] = int'(out_count);
      cap_d[cap_n % 256] = done;
      cap_n = cap_n + 1;
    end
  end

  // expected pairs from the bench's own model
  int exp_n;
  logic [7:0] exp_v [32];
  int exp_c [32];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model(input int vi);
    int len;
    int k;
    len = STIM_LEN[vi];
    exp_n = 0;
    k = 0;
    while (k < len) begin
      int rep;
      rep = 1;
      while (k + rep < len && STIM[vi][k+rep] == STIM[vi][k] && rep < 7) rep++;
      exp_v[exp_n] = STIM[vi][k];
      exp_c[exp_n] = rep;
      exp_n++;
      k += rep;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // gaps: idle cycles between bytes (R6); mid_start: a start inside the stream (R8)
  task automatic run_vec(input int vi, input bit gaps, input bit mid_start);
    int base;
    int w;
    base = cap_n;
    model(vi);
    @(negedge clk);
    start = 1'b1; total_len = 16'(STIM_LEN[vi]);
    @(negedge clk);
    start = 1'b0;
    chk(!done && busy, $sformatf("R10 vec%0d done/busy after start", vi),
        int'({done, busy}), 1);
    for (int i = 0; i < STIM_LEN[vi]; i++) begin
      in_valid = 1'b1; in_data = STIM[vi][i];
      start = mid_start && (i == 3);
      if (start) total_len = 16'd2;
      @(negedge clk);
      start = 1'b0;
      if (gaps) begin
        in_valid = 1'b0; in_data = in_data ^ 8'h5A;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    w = 0;
    while (!done && w < 20) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
    chk(cap_n - base == exp_n, $sformatf("R2 vec%0d pair count", vi), cap_n - base, exp_n);
    for (int p = 0; p < exp_n && p < cap_n - base; p++) begin
      chk(cap_v[(base+p)%256] == exp_v[p], $sformatf("R2 vec%0d pair%0d value", vi, p),
          int'(cap_v[(base+p)%256]), int'(exp_v[p]));
      chk(cap_c[(base+p)%256] == exp_c[p], $sformatf("R3 vec%0d pair%0d count", vi, p),
          cap_c[(base+p)%256], exp_c[p]);
      chk(cap_d[(base+p)%256] == (p == exp_n - 1), $sformatf("R5 vec%0d pair%0d done flag", vi, p),
          int'(cap_d[(base+p)%256]), int'(p == exp_n - 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n0;
    do_reset();
    // R1: reset state
    chk(!out_valid && !done && !busy, "R1 outputs after reset",
        int'({out_valid, done, busy}), 0);

    // R7: input before any start is ignored
    n0 = cap_n;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_data = 8'(i); @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cap_n == n0, "R7 no pairs before start", cap_n - n0, 0);
    chk(!busy && !done, "R7 still idle", int'({busy, done}), 0);

    // table-driven streams (R2, R3, R4, R5, R10)
    for (int v = 0; v < NV; v++) run_vec(v, v % 2 == 1, 1'b0);

    // R7: input after done is ignored
    n0 = cap_n;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = 8'h99; @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(cap_n == n0, "R7 no pairs after done", cap_n - n0, 0);
    chk(done == 1'b1, "R7 done held", int'(done), 1);

    // R6: stream with idle gaps and changing junk data
    run_vec(7, 1'b1, 1'b0);

    // R8: start inside a running stream has no effect
    run_vec(0, 1'b0, 1'b1);

    // R9: zero-length stream
    n0 = cap_n;
    @(negedge clk);
    start = 1'b1; total_len = 16'd0;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy, "R9 done after empty start", int'({done, busy}), 2);
    repeat (3) @(negedge clk);
    chk(cap_n == n0, "R9 no pairs for empty stream", cap_n - n0, 0);

    // R11: reset in mid-stream
    @(negedge clk);
    start = 1'b1; total_len = 16'd8;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_data = STIM[0][i]; @(negedge clk);
    end
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!out_valid && !done && !busy, "R11 outputs after mid-stream reset",
        int'({out_valid, done, busy}), 0);
    n0 = cap_n;
    repeat (5) @(negedge clk);
    chk(cap_n == n0, "R11 pending run dropped", cap_n - n0, 0);
    run_vec(1, 1'b0, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule